// File: doc/BRIEF.md
# Overcurrent Protection and Restart Sequencer

This block is the digital side of the overcurrent protection in a switching power controller. Each switching cycle it receives a cycle-start tick, the PWM request for the energizing switch and the overcurrent comparator output. It returns the gated energizing drive, the rectifier enable and the soft-start reference code. A static mode strap selects one of two protection schemes. In pulse-by-pulse mode an overcurrent ends the energizing pulse at once, for the rest of that switching cycle. In hiccup mode overcurrent cycles are tallied in a saturating up/down counter. When the net tally reaches the trip value, both switches are held off for a fixed number of switching cycles, and a soft-start then follows on its own.

The comparator output is ignored for a set number of clocks after the energizing request rises, so that switching noise at turn-on is not taken for an overcurrent. A soft-start also runs out of reset. During soft-start the reference code climbs from zero to full scale, one step after a fixed number of switching cycles. The rectifier stays disabled after reset, and after every hiccup trip, until a loop-ready flag from the error amplifier has been seen.

Top module: `ocp_hiccup_seq`

## Requirements
- R1: During and right after reset, with all inputs low: soft-start is active, hiccup is inactive, the reference code is 0, and both drive enables are 0.
- R2: A high `oc_pulse_i` has no effect in the first BLANK_CLK clocks in which `drive_on_i` is high (counted from its rise). Such a pulse neither cuts the drive nor counts as an event.
- R3: With `mode_pbp_i` high, an unblanked overcurrent drops `drive_en_o` in the same clock. The drive then stays low until the next `cyc_tick_i`.
- R4: With `mode_pbp_i` high, the block never enters hiccup, however many overcurrent cycles occur.
- R5: With `mode_pbp_i` low, the event counter is updated at each tick outside hiccup. It counts up if the ending switching cycle had an unblanked overcurrent, and down otherwise. It saturates at 0, and it is held at 0 while `mode_pbp_i` is high.
- R6: The counter trips when an event cycle is counted while it already holds 2^CNT_W-2, which makes the 2^CNT_W-1th net event. At the clock edge of that tick, `hiccup_o` rises and the counter clears. While `hiccup_o` is high, `drive_en_o` and `rect_en_o` are 0.
- R7: Hiccup lasts exactly OFF_CYC ticks. At the edge of the last of these ticks, `hiccup_o` falls and soft-start begins with the reference code at 0.
- R8: In soft-start the reference code rises by 1 at every SS_STEP-th tick. Soft-start ends at the edge where the code reaches 2^REF_W-1. The code then holds that value for as long as the block runs.
- R9: `rect_en_o` equals `comp_ready_i` until the flag has been seen outside hiccup. From then on it stays 1 until the next trip, and it is 0 during hiccup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_pbp_i | input | 1 | 1: pulse-by-pulse limit, 0: hiccup protection |
| cyc_tick_i | input | 1 | One-clock pulse at the start of each switching cycle |
| drive_on_i | input | 1 | PWM request for the energizing switch |
| oc_pulse_i | input | 1 | Overcurrent comparator output |
| comp_ready_i | input | 1 | Error amplifier output has reached the rectifier enable level |
| drive_en_o | output | 1 | Gated energizing switch drive |
| rect_en_o | output | 1 | Rectifier switch enable |
| hiccup_o | output | 1 | Hiccup off period active |
| ss_active_o | output | 1 | Soft-start active |
| ref_code_o | output | REF_W | Soft-start reference code |

## Verification
The bench builds the block with CNT_W=3, OFF_CYC=5, REF_W=3, SS_STEP=2 and BLANK_CLK=2. With these values a trip takes seven net events, an off period takes five cycles and a full ramp takes fourteen cycles. The bench can therefore drive several trip, off-period and restart sequences in a few hundred clocks. The stimulus checks that clean cycles cannot bank credit below zero. It also covers a tally that stops one event short of the trip, a drive cut with the switching cycle already under way, and overcurrent pulses that arrive during the off period.

// File: rtl/ocp_pkg.sv
package ocp_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_OFF  = 2'd1,
    ST_SOFT = 2'd2
  } seq_state_e;
endpackage

// File: rtl/ocp_blank.sv
module ocp_blank #(
  parameter int BLANK_CLK = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic drive_on_i,
  input  logic oc_pulse_i,
  output logic oc_valid_o
);
  generate
    if (BLANK_CLK == 0) begin : g_noblank
      assign oc_valid_o = oc_pulse_i & drive_on_i;
    end else begin : g_blank
      localparam int BW = $clog2(BLANK_CLK + 1);
      localparam logic [BW-1:0] BLIM = BW'(BLANK_CLK);
      logic [BW-1:0] on_cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                on_cnt_q <= '0;
        else if (!drive_on_i)       on_cnt_q <= '0;
        else if (on_cnt_q != BLIM)  on_cnt_q <= on_cnt_q + 1'b1;
      end
      assign oc_valid_o = oc_pulse_i & drive_on_i & (on_cnt_q == BLIM);
    end
  endgenerate
endmodule

// File: rtl/ocp_evt_cnt.sv
module ocp_evt_cnt #(
  parameter int CNT_W = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tick_i,
  input  logic event_i,
  output logic trip_o
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CPRE = CMAX - 1'b1;

  logic [CNT_W-1:0] cnt_q;

  assign trip_o = tick_i & event_i & ~clr_i & (cnt_q == CPRE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (tick_i) begin
      if (trip_o)             cnt_q <= '0;
      else if (event_i)       cnt_q <= (cnt_q == CMAX) ? cnt_q : cnt_q + 1'b1;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/ocp_seq_ctrl.sv
module ocp_seq_ctrl
  import ocp_pkg::*;
#(
  parameter int OFF_CYC = 882,
  parameter int REF_W   = 8,
  parameter int SS_STEP = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             trip_i,
  input  logic             comp_ready_i,
  output seq_state_e       state_o,
  output logic [REF_W-1:0] ref_code_o,
  output logic             rect_ok_o
);
  localparam int OW = (OFF_CYC > 1) ? $clog2(OFF_CYC) : 1;
  localparam int SW = (SS_STEP > 1) ? $clog2(SS_STEP) : 1;
  localparam logic [OW-1:0]    OFF_LAST  = OW'(OFF_CYC - 1);
  localparam logic [SW-1:0]    STEP_LAST = SW'(SS_STEP - 1);
  localparam logic [REF_W-1:0] REF_PRE   = {{(REF_W-1){1'b1}}, 1'b0};

  seq_state_e       state_q;
  logic [OW-1:0]    off_q;
  logic [SW-1:0]    step_q;
  logic [REF_W-1:0] ref_q;
  logic             rok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_SOFT;
      off_q   <= '0;
      step_q  <= '0;
      ref_q   <= '0;
      rok_q   <= 1'b0;
    end else if (trip_i) begin
      state_q <= ST_OFF;
      off_q   <= '0;
      ref_q   <= '0;
      rok_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_OFF: if (tick_i) begin
          if (off_q == OFF_LAST) begin
            state_q <= ST_SOFT;
            step_q  <= '0;
            ref_q   <= '0;
          end else begin
            off_q <= off_q + 1'b1;
          end
        end
        ST_SOFT: if (tick_i) begin
          if (step_q == STEP_LAST) begin
            step_q <= '0;
            ref_q  <= ref_q + 1'b1;
            if (ref_q == REF_PRE) state_q <= ST_RUN;
          end else begin
            step_q <= step_q + 1'b1;
          end
        end
        default: ;
      endcase
      if (state_q != ST_OFF && comp_ready_i) rok_q <= 1'b1;
    end
  end

  assign state_o    = state_q;
  assign ref_code_o = ref_q;
  assign rect_ok_o  = rok_q;
endmodule

// File: rtl/ocp_hiccup_seq.sv
module ocp_hiccup_seq
  import ocp_pkg::*;
#(
  parameter int CNT_W     = 6,
  parameter int OFF_CYC   = 882,
  parameter int REF_W     = 8,
  parameter int SS_STEP   = 8,
  parameter int BLANK_CLK = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_pbp_i,
  input  logic             cyc_tick_i,
  input  logic             drive_on_i,
  input  logic             oc_pulse_i,
  input  logic             comp_ready_i,
  output logic             drive_en_o,
  output logic             rect_en_o,
  output logic             hiccup_o,
  output logic             ss_active_o,
  output logic [REF_W-1:0] ref_code_o
);
  seq_state_e state;
  logic oc_valid, trip, rect_ok, run_ok;
  logic cut_q, ev_q;

  ocp_blank #(.BLANK_CLK(BLANK_CLK)) u_blank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .drive_on_i (drive_on_i),
    .oc_pulse_i (oc_pulse_i),
    .oc_valid_o (oc_valid)
  );

  ocp_evt_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (mode_pbp_i),
    .tick_i  (cyc_tick_i & run_ok),
    .event_i (ev_q | oc_valid),
    .trip_o  (trip)
  );

  ocp_seq_ctrl #(.OFF_CYC(OFF_CYC), .REF_W(REF_W), .SS_STEP(SS_STEP)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (cyc_tick_i),
    .trip_i       (trip),
    .comp_ready_i (comp_ready_i),
    .state_o      (state),
    .ref_code_o   (ref_code_o),
    .rect_ok_o    (rect_ok)
  );

  assign run_ok = (state != ST_OFF);

  // per-cycle flags: cut holds pulse-by-pulse termination, ev marks an event cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cut_q <= 1'b0;
      ev_q  <= 1'b0;
    end else if (cyc_tick_i) begin
      cut_q <= 1'b0;
      ev_q  <= 1'b0;
    end else begin
      if (oc_valid && mode_pbp_i) cut_q <= 1'b1;
      if (oc_valid)               ev_q  <= 1'b1;
    end
  end

  assign drive_en_o  = drive_on_i & run_ok & ~cut_q & ~(oc_valid & mode_pbp_i);
  assign rect_en_o   = run_ok & (rect_ok | comp_ready_i);
  assign hiccup_o    = (state == ST_OFF);
  assign ss_active_o = (state == ST_SOFT);
endmodule

// File: rtl/ocp_hiccup_chk.sv
module ocp_hiccup_chk #(
  parameter int OFF_CYC = 882,
  parameter int REF_W   = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mode_pbp_i,
  input logic             cyc_tick_i,
  input logic             drive_on_i,
  input logic             oc_pulse_i,
  input logic             comp_ready_i,
  input logic             drive_en_o,
  input logic             rect_en_o,
  input logic             hiccup_o,
  input logic             ss_active_o,
  input logic [REF_W-1:0] ref_code_o
);
  localparam int TW = $clog2(OFF_CYC + 1) + 1;
  localparam logic [REF_W-1:0] FULL = {REF_W{1'b1}};
  logic [TW-1:0] off_ticks_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      off_ticks_q <= '0;
    else if (!hiccup_o)               off_ticks_q <= '0;
    else if (cyc_tick_i)              off_ticks_q <= off_ticks_q + 1'b1;
  end

  assert_off_gates_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hiccup_o |-> (!drive_en_o && !rect_en_o));

  assert_pbp_cut_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drive_on_i && $past(drive_on_i) && $past(drive_en_o) && !drive_en_o && !hiccup_o)
      |-> (mode_pbp_i && oc_pulse_i));

  assert_pbp_no_trip_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hiccup_o) |-> (!$past(mode_pbp_i) && $past(cyc_tick_i)));

  assert_off_len_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hiccup_o) |-> (off_ticks_q == TW'(OFF_CYC) && ss_active_o && ref_code_o == '0));

  assert_ref_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(hiccup_o) |-> ((ref_code_o - $past(ref_code_o)) <= REF_W'(1)));

  assert_run_full_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ss_active_o && !hiccup_o) |-> (ref_code_o == FULL));

  assert_one_phase_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hiccup_o && ss_active_o));

  assert_rect_rise_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rect_en_o && !$past(rect_en_o)) |-> comp_ready_i);
endmodule

bind ocp_hiccup_seq ocp_hiccup_chk #(.OFF_CYC(OFF_CYC), .REF_W(REF_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mode_pbp_i   (mode_pbp_i),
  .cyc_tick_i   (cyc_tick_i),
  .drive_on_i   (drive_on_i),
  .oc_pulse_i   (oc_pulse_i),
  .comp_ready_i (comp_ready_i),
  .drive_en_o   (drive_en_o),
  .rect_en_o    (rect_en_o),
  .hiccup_o     (hiccup_o),
  .ss_active_o  (ss_active_o),
  .ref_code_o   (ref_code_o)
);

// File: tb/tb_ocp_hiccup_seq.sv
`timescale 1ns/1ps
module tb_ocp_hiccup_seq;
  localparam int CNT_W = 3, OFF_CYC = 5, REF_W = 3, SS_STEP = 2, BLANK_CLK = 2;
  localparam int TRIP = (1 << CNT_W) - 1;
  localparam int FULL = (1 << REF_W) - 1;
  localparam int EW = 4 + REF_W;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic mode_pbp = 1'b0, tick = 1'b0, don = 1'b0, oc = 1'b0, crdy = 1'b0;
  logic drive_en, rect_en, hic, ss;
  logic [REF_W-1:0] refc;

  always #2 clk = ~clk;

  ocp_hiccup_seq #(.CNT_W(CNT_W), .OFF_CYC(OFF_CYC), .REF_W(REF_W),
                   .SS_STEP(SS_STEP), .BLANK_CLK(BLANK_CLK)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_pbp_i(mode_pbp), .cyc_tick_i(tick),
    .drive_on_i(don), .oc_pulse_i(oc), .comp_ready_i(crdy),
    .drive_en_o(drive_en), .rect_en_o(rect_en), .hiccup_o(hic),
    .ss_active_o(ss), .ref_code_o(refc));

  int checks = 0, fails = 0;
  bit done = 1'b0;
  string cur_req = "R1";
  logic [EW-1:0] exp_q[$];
  string tag_q[$];

  // requirement model state: 0 run, 1 off, 2 soft-start
  int m_st = 2, m_on = 0, m_cnt = 0, m_off = 0, m_step = 0, m_ref = 0;
  bit m_cut = 0, m_ev = 0, m_rok = 0;
  int hic_seen = 0;

  task automatic clk_step(input bit t, input bit d, input bit o, input bit c);
    bit valid, run_ok, evt, trip, e_drv, e_rect;
    @(posedge clk); #1;
    tick = t; don = d; oc = o; crdy = c;
    valid  = o && d && (m_on == BLANK_CLK);
    run_ok = (m_st != 1);
    e_drv  = d && run_ok && !m_cut && !(valid && mode_pbp);
    e_rect = run_ok && (m_rok || c);
    exp_q.push_back({e_drv, e_rect, m_st == 1, m_st == 2, REF_W'(m_ref)});
    tag_q.push_back(cur_req);
    evt  = m_ev || valid;
    trip = t && run_ok && !mode_pbp && evt && (m_cnt == TRIP - 1);
    m_on = d ? ((m_on < BLANK_CLK) ? m_on + 1 : m_on) : 0;
    if (t) begin m_cut = 0; m_ev = 0; end
    else begin
      if (valid && mode_pbp) m_cut = 1;
      if (valid) m_ev = 1;
    end
    if (mode_pbp) m_cnt = 0;
    else if (t && run_ok) begin
      if (trip) m_cnt = 0;
      else if (evt) m_cnt = (m_cnt < TRIP) ? m_cnt + 1 : m_cnt;
      else if (m_cnt > 0) m_cnt = m_cnt - 1;
    end
    if (trip) begin m_st = 1; m_off = 0; m_ref = 0; m_rok = 0; end
    else begin
      if (m_st == 1 && t) begin
        if (m_off == OFF_CYC - 1) begin m_st = 2; m_step = 0; m_ref = 0; end
        else m_off = m_off + 1;
      end else if (m_st == 2 && t) begin
        if (m_step == SS_STEP - 1) begin
          m_step = 0;
          if (m_ref == FULL - 1) m_st = 0;
          m_ref = m_ref + 1;
        end else m_step = m_step + 1;
      end
      if (run_ok && c) m_rok = 1;
    end
  endtask

  // one switching cycle of 6 clocks; drive requested in clocks 0..3
  task automatic sw_cycle(input int oc_slot, input bit c);
    for (int k = 0; k < 6; k++)
      clk_step(k == 0, k < 4, k == oc_slot, c);
  endtask

  task automatic chk(input string req, input logic [EW-1:0] act, input logic [EW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got drv/rect/hic/ss/ref=%b expected %b", req, act, exp);
    end
  endtask

  // monitor: pops expected items and compares away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      if (hic) hic_seen++;
      if (exp_q.size() > 0) chk(tag_q.pop_front(), {drive_en, rect_en, hic, ss, refc},
                                exp_q.pop_front());
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got no completion expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", {drive_en, rect_en, hic, ss, refc}, {1'b0, 1'b0, 1'b0, 1'b1, REF_W'(0)});
    @(posedge clk); #1 rst_ni = 1'b1;
    @(negedge clk);
    chk("R1", {drive_en, rect_en, hic, ss, refc}, {1'b0, 1'b0, 1'b0, 1'b1, REF_W'(0)});

    // soft-start from reset, loop-ready flag pulses once
    mode_pbp = 1'b0;
    for (int i = 0; i < 16; i++) begin
      cur_req = (i < 6) ? "R9" : "R8";
      sw_cycle(-1, i == 3);
    end
    @(negedge clk);
    chk("R8", {1'b0, 1'b0, hic, ss, refc}, {1'b0, 1'b0, 1'b0, 1'b0, REF_W'(FULL)});

    // pulses inside the blanking window
    cur_req = "R2";
    for (int i = 0; i < 10; i++) sw_cycle(1, 1'b0);
    mode_pbp = 1'b1;
    for (int i = 0; i < 4; i++) sw_cycle(1, 1'b0);

    // pulse-by-pulse limiting, many overcurrent cycles
    hic_seen = 0;
    for (int i = 0; i < 3 * TRIP; i++) begin
      cur_req = (i % 2 == 0) ? "R3" : "R4";
      sw_cycle(2, 1'b0);
    end
    @(negedge clk);
    checks++;
    if (hic_seen != 0) begin
      fails++;
      $display("FAIL R4: got hiccup clocks=%0d expected 0", hic_seen);
    end

    // hiccup tally: credit cannot go below zero, one short of trip
    mode_pbp = 1'b0;
    cur_req = "R5";
    for (int i = 0; i < 3; i++) sw_cycle(3, 1'b0);
    for (int i = 0; i < 8; i++) sw_cycle(-1, 1'b0);
    for (int i = 0; i < TRIP - 1; i++) sw_cycle(3, 1'b0);
    sw_cycle(-1, 1'b0);
    sw_cycle(3, 1'b0);
    sw_cycle(-1, 1'b0);
    @(negedge clk);
    checks++;
    if (hic !== 1'b0) begin
      fails++;
      $display("FAIL R5: got hiccup=%b expected 0", hic);
    end
    cur_req = "R6";
    for (int i = 0; i < TRIP - 1; i++) sw_cycle(3, 1'b0);
    sw_cycle(-1, 1'b0);
    @(negedge clk);
    checks++;
    if (hic !== 1'b1) begin
      fails++;
      $display("FAIL R6: got hiccup=%b expected 1", hic);
    end

    // off period with pulses and ready flag present, then restart
    cur_req = "R7";
    for (int i = 0; i < OFF_CYC + 1; i++) sw_cycle(3, 1'b1);
    for (int i = 0; i < 16; i++) begin
      cur_req = (i < 9) ? "R9" : "R8";
      sw_cycle(-1, i == 7);
    end

    // second trip straight from run, then full recovery
    cur_req = "R6";
    for (int i = 0; i < TRIP + 1; i++) sw_cycle(2, 1'b0);
    cur_req = "R7";
    for (int i = 0; i < OFF_CYC + 2; i++) sw_cycle(-1, 1'b0);
    cur_req = "R8";
    for (int i = 0; i < 14; i++) sw_cycle(-1, 1'b1);

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule